// File: doc/BRIEF.md
# Transmit Descriptor Poll Scheduler

This block decides when the buffer manager of a network controller fetches the next transmit descriptor. A free-running interval timer asks for automatic polls. A software demand pulse asks for a manual poll. The block turns both into one poll request, which it holds until the descriptor fetch logic acknowledges it.

A disable bit turns the automatic path off, so that only demands start a poll. While the transmitter-on status is low, nothing is issued and anything pending is dropped. While the receive side reports activity, a pending poll waits. The block also holds the disable bit and the poll interval, each with its reset behaviour.

Top module: `txpoll_sched`

## Requirements
- R1: After `rst_n` is released, `poll_req` is 0 and `poll_disable` is 0. The poll interval starts at 4096 cycles, so with `tx_on` high from reset the first automatic request appears on the 4097th rising edge after release.
- R2: The disable bit can always be read and written. A write with `dis_wr` high shows `dis_wdata` on `poll_disable` from the next edge on.
- R3: A `soft_rst` pulse clears `poll_disable`, drops `poll_req`, cancels pending polls and restores the default interval.
- R4: With the disable bit at 0, `tx_on` high and `rx_busy` low, an automatic request rises N+1 edges after the timer starts from zero. N is the programmed interval. The timer starts from zero when `tx_on` rises and at every acknowledged poll.
- R5: With the disable bit at 1, no automatic request is ever made.
- R6: A `tx_demand` pulse sampled at an edge while `tx_on` is high is latched, and `poll_req` rises at the following edge. This works with the disable bit at either value.
- R7: Several demands that arrive before the resulting poll is acknowledged merge into a single request.
- R8: Only one request is outstanding at a time. `poll_req` stays high until `poll_done` is sampled high, and it is low after that edge.
- R9: While `tx_on` is low, `poll_req` is low after the next edge. Demands are ignored, and any latched demand or timer expiry is cancelled.
- R10: A request is raised only from a cycle in which `rx_busy` is low. A pending poll waits out receive activity.
- R11: A demand sampled in the same cycle as an acknowledge is kept. It yields a new request two edges later.
- R12: The interval is written through `ivl_wr`/`ivl_wdata`. A written value of 0 is stored as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Synchronous software reset pulse |
| dis_wr | input | 1 | Write strobe for the disable bit |
| dis_wdata | input | 1 | Disable bit value to write (1 = automatic polling off) |
| poll_disable | output | 1 | Current disable bit |
| ivl_wr | input | 1 | Write strobe for the poll interval |
| ivl_wdata | input | CNT_W | Poll interval in clock cycles |
| tx_demand | input | 1 | Software transmit-demand pulse |
| tx_on | input | 1 | Transmitter-on status |
| rx_busy | input | 1 | Receive activity in progress |
| poll_req | output | 1 | Poll request to the descriptor fetch logic |
| poll_done | input | 1 | Poll-done acknowledge |

## Verification
An acknowledge and a fresh software demand can land in the same cycle. The acknowledge clears the latch while the new demand sets it. The bench provokes this by raising `tx_demand` on the exact cycle it drives `poll_done`. It passes only if the request drops for one cycle and then rises again. The second overlap is a pending poll meeting receive activity. Here the bench holds `rx_busy` high across several demands and checks that a single request appears one edge after `rx_busy` falls.

// File: rtl/txpoll_pkg.sv
package txpoll_pkg;
    // Arbiter state: latched demand and outstanding request.
    typedef struct packed {
        logic dem;
        logic req;
    } arb_st_t;
endpackage

// File: rtl/txpoll_ctl_regs.sv
module txpoll_ctl_regs #(
    parameter int CNT_W   = 16,
    parameter int DEF_IVL = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             dis_wr,
    input  logic             dis_wdata,
    input  logic             ivl_wr,
    input  logic [CNT_W-1:0] ivl_wdata,
    output logic             dis,
    output logic [CNT_W-1:0] ivl
);
    localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_IVL);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    typedef struct packed {
        logic             dis;
        logic [CNT_W-1:0] ivl;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (soft_rst) begin
            ctl_d.dis = 1'b0;
            ctl_d.ivl = DEF_V;
        end else begin
            if (dis_wr) ctl_d.dis = dis_wdata;
            if (ivl_wr) ctl_d.ivl = (ivl_wdata == '0) ? ONE_V : ivl_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.dis <= 1'b0;
            ctl_q.ivl <= DEF_V;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dis = ctl_q.dis;
    assign ivl = ctl_q.ivl;
endmodule

// File: rtl/txpoll_timer.sv
module txpoll_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             run,
    input  logic             hold,
    input  logic             restart,
    input  logic [CNT_W-1:0] ivl,
    output logic             due
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             due;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] last_v;

    assign last_v = ivl - CNT_W'(1);

    always_comb begin
        tmr_d = tmr_q;
        if (soft_rst || !run || restart) begin
            tmr_d.cnt = '0;
            tmr_d.due = 1'b0;
        end else if (tmr_q.due || hold) begin
            tmr_d = tmr_q;
        end else if (tmr_q.cnt >= last_v) begin
            tmr_d.due = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= '0;
            tmr_q.due <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign due = tmr_q.due;
endmodule

// File: rtl/txpoll_arbiter.sv
module txpoll_arbiter
    import txpoll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic tx_on,
    input  logic rx_busy,
    input  logic demand,
    input  logic auto_due,
    input  logic done,
    output logic req,
    output logic ack_fire
);
    arb_st_t st_d, st_q;

    assign ack_fire = st_q.req & done;

    always_comb begin
        st_d     = st_q;
        st_d.dem = tx_on & ~soft_rst & ((st_q.dem & ~ack_fire) | demand);
        if (soft_rst || !tx_on) begin
            st_d.req = 1'b0;
        end else if (st_q.req) begin
            st_d.req = ~done;
        end else begin
            st_d.req = ~rx_busy & (st_q.dem | auto_due);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dem <= 1'b0;
            st_q.req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;
endmodule

// File: rtl/txpoll_sched.sv
module txpoll_sched #(
    parameter int CNT_W   = 16,
    parameter int DEF_IVL = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             dis_wr,
    input  logic             dis_wdata,
    output logic             poll_disable,
    input  logic             ivl_wr,
    input  logic [CNT_W-1:0] ivl_wdata,
    input  logic             tx_demand,
    input  logic             tx_on,
    input  logic             rx_busy,
    output logic             poll_req,
    input  logic             poll_done
);
    logic             dis_w;
    logic [CNT_W-1:0] ivl_w;
    logic             due_w;
    logic             ack_w;
    logic             req_w;

    txpoll_ctl_regs #(.CNT_W(CNT_W), .DEF_IVL(DEF_IVL)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .dis_wr(dis_wr), .dis_wdata(dis_wdata),
        .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
        .dis(dis_w), .ivl(ivl_w)
    );

    txpoll_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .run(tx_on & ~dis_w), .hold(req_w), .restart(ack_w),
        .ivl(ivl_w), .due(due_w)
    );

    txpoll_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .tx_on(tx_on), .rx_busy(rx_busy), .demand(tx_demand),
        .auto_due(due_w), .done(poll_done),
        .req(req_w), .ack_fire(ack_w)
    );

    assign poll_disable = dis_w;
    assign poll_req     = req_w;
endmodule

// File: rtl/txpoll_sched_chk.sv
module txpoll_sched_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             dis_wr,
    input logic             dis_wdata,
    input logic             poll_disable,
    input logic             ivl_wr,
    input logic [CNT_W-1:0] ivl_wdata,
    input logic             tx_demand,
    input logic             tx_on,
    input logic             rx_busy,
    input logic             poll_req,
    input logic             poll_done
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !poll_done && tx_on && !soft_rst) |=> poll_req);
    // R8
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && poll_done) |=> !poll_req);
    // R9
    txoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |=> !poll_req);
    // R10
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(poll_req) |-> $past(!rx_busy));
    // R3
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!poll_disable && !poll_req));
    // R2
    dis_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_wr && !soft_rst) |=> (poll_disable == $past(dis_wdata)));
endmodule

bind txpoll_sched txpoll_sched_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_txpoll_sched.sv
module tb_txpoll_sched;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic dis_wr = 1'b0;
    logic dis_wdata = 1'b0;
    logic ivl_wr = 1'b0;
    logic [CNT_W-1:0] ivl_wdata = '0;
    logic tx_demand = 1'b0;
    logic tx_on = 1'b0;
    logic rx_busy = 1'b0;
    logic poll_done = 1'b0;
    logic poll_disable;
    logic poll_req;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    txpoll_sched #(.CNT_W(CNT_W), .DEF_IVL(4096)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .dis_wr(dis_wr), .dis_wdata(dis_wdata), .poll_disable(poll_disable),
        .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
        .tx_demand(tx_demand), .tx_on(tx_on), .rx_busy(rx_busy),
        .poll_req(poll_req), .poll_done(poll_done)
    );

    typedef struct packed {
        logic [15:0] ivl;
        logic        dis;
        logic        dem;
        logic [15:0] lat;   // 0 = no request expected
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd5,  1'b0, 1'b0, 16'd6},
        '{16'd12, 1'b0, 1'b0, 16'd13},
        '{16'd1,  1'b0, 1'b0, 16'd2},
        '{16'd8,  1'b1, 1'b1, 16'd2},
        '{16'd8,  1'b1, 1'b0, 16'd0},
        '{16'd20, 1'b0, 1'b1, 16'd2},
        '{16'd3,  1'b1, 1'b0, 16'd0},
        '{16'd2,  1'b0, 1'b0, 16'd3},
        '{16'd0,  1'b0, 1'b0, 16'd2}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cfg(input logic d, input logic [CNT_W-1:0] iv);
        tx_on = 1'b0; poll_done = 1'b0; tx_demand = 1'b0;
        tick();
        dis_wr = 1'b1; dis_wdata = d; ivl_wr = 1'b1; ivl_wdata = iv;
        tick();
        dis_wr = 1'b0; ivl_wr = 1'b0;
        tick();
    endtask

    task automatic ack();
        poll_done = 1'b1;
        tick();
        poll_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int lat;
        // R1 reset state and default interval
        tx_on = 1'b1;
        repeat (3) tick();
        chk(poll_req == 1'b0, "R1 req in reset", poll_req, 0);
        chk(poll_disable == 1'b0, "R1 disable in reset", poll_disable, 0);
        rst_n = 1'b1;
        lat = 0;
        for (int k = 1; k <= 4200; k++) begin
            tick();
            if (lat == 0 && poll_req) lat = k;
        end
        chk(lat == 4097, "R1 R4 default interval latency", lat, 4097);
        // R8 request stays while no acknowledge
        chk(poll_req == 1'b1, "R8 held without ack", poll_req, 1);
        ack();
        chk(poll_req == 1'b0, "R8 released after ack", poll_req, 0);

        // Vector table: R4 R5 R6 R12
        for (int i = 0; i < NV; i++) begin
            cfg(VECS[i].dis, VECS[i].ivl);
            tx_on = 1'b1; tx_demand = VECS[i].dem;
            lat = 0;
            for (int k = 1; k <= int'(VECS[i].ivl) + 5; k++) begin
                tick();
                tx_demand = 1'b0;
                if (lat == 0 && poll_req) lat = k;
            end
            chk(lat == int'(VECS[i].lat), "R4 R5 R6 R12 vector latency", lat, int'(VECS[i].lat));
            ack();
            chk(poll_req == 1'b0, "R8 vector ack", poll_req, 0);
        end

        // R2 disable bit read/write
        cfg(1'b0, 16'd50);
        dis_wr = 1'b1; dis_wdata = 1'b1; tick(); dis_wr = 1'b0;
        chk(poll_disable == 1'b1, "R2 write one", poll_disable, 1);
        dis_wr = 1'b1; dis_wdata = 1'b0; tick(); dis_wr = 1'b0;
        chk(poll_disable == 1'b0, "R2 write zero", poll_disable, 0);

        // R3 soft reset clears disable bit and request
        cfg(1'b1, 16'd50);
        tx_on = 1'b1; tx_demand = 1'b1; tick(); tx_demand = 1'b0; tick();
        chk(poll_req == 1'b1, "R6 demand raises request", poll_req, 1);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        chk(poll_disable == 1'b0, "R3 soft reset disable", poll_disable, 0);
        chk(poll_req == 1'b0, "R3 soft reset request", poll_req, 0);

        // R10 receive activity holds the poll, R7 demands merge
        cfg(1'b1, 16'd50);
        tx_on = 1'b1; rx_busy = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tx_demand = 1'b1; tick();
        end
        tx_demand = 1'b0;
        repeat (6) tick();
        chk(poll_req == 1'b0, "R10 held during rx", poll_req, 0);
        rx_busy = 1'b0; tick();
        chk(poll_req == 1'b1, "R10 issued after rx", poll_req, 1);
        ack();
        lat = 0;
        for (int k = 0; k < 10; k++) begin
            tick();
            if (poll_req) lat++;
        end
        chk(lat == 0, "R7 merged into one poll", lat, 0);

        // R11 demand in the acknowledge cycle
        tx_demand = 1'b1; tick(); tx_demand = 1'b0; tick();
        chk(poll_req == 1'b1, "R11 first request", poll_req, 1);
        poll_done = 1'b1; tx_demand = 1'b1; tick();
        poll_done = 1'b0; tx_demand = 1'b0;
        chk(poll_req == 1'b0, "R11 gap after ack", poll_req, 0);
        tick();
        chk(poll_req == 1'b1, "R11 second request", poll_req, 1);
        ack();

        // R9 transmitter off drops request and cancels demand
        tx_demand = 1'b1; tick(); tx_demand = 1'b0; tick();
        chk(poll_req == 1'b1, "R9 request before off", poll_req, 1);
        tx_on = 1'b0; tick();
        chk(poll_req == 1'b0, "R9 dropped when off", poll_req, 0);
        tx_demand = 1'b1; tick(); tx_demand = 1'b0; tick();
        tx_on = 1'b1;
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            tick();
            if (poll_req) lat++;
        end
        chk(lat == 0, "R9 demand while off ignored", lat, 0);

        finish_run();
    end
endmodule